// File: doc/BRIEF.md
# Banked DRAM Access and Refresh Controller

This block sits between a synchronous processor bus and an asynchronous DRAM array built as four banks. A processor request carries a bank/row/column address, a read/write flag, four byte enables and a page-hold flag. The controller turns it into a row strobe for the selected bank, a multiplexed row-then-column address, column strobes and a write enable. While the access cannot yet finish, a wait output stretches the processor cycle. The processor holds its request until it sees the wait output low at a rising edge, and changes or drops it right after that edge.

A free-running interval counter raises refresh requests. Refresh is arbitrated against processor accesses in the idle state and always wins there. Each refresh is a column-before-row cycle in which all four row strobes fall together. Each bank has its own precharge counter. A bank that has just closed blocks only a new access to that same bank, or a refresh, which needs every bank precharged. When page hold is set, the row is kept open after the access, so a later request to the same bank and row skips the row phase.

Top module: `dram_ctl`

## Requirements
- R1: Out of reset all row strobes, all column strobes and the write enable are high (inactive), the DRAM address is zero, and the wait output is low while no request is present.
- R2: An accepted access drives the row strobe of its bank low with the row address after the first clock. The column address follows after the second clock. All enabled column strobes fall after the third clock and stay low for T_CAS cycles. Then row and column strobes rise together. At most one row strobe is low outside a refresh, and the address does not change while a column strobe stays low.
- R3: On a write, the write enable is low from the column-address cycle until the column strobes rise, and column strobe i (active low) falls only where byte enable bit i is 1. On a read, all four column strobes fall and the write enable stays high.
- R4: The wait output is high while a request is present and the access is not in its final column-strobe cycle. It is low in that final cycle, and the column strobes are high in the cycle after it. The wait output is low whenever no request is present.
- R5: After a bank's row strobe rises, it stays high for at least T_PRE cycles. A back-to-back access to the same bank therefore sees T_PRE + T_CAS + 1 wait cycles.
- R6: A back-to-back access to a different, already precharged bank sees no precharge delay: T_CAS + 2 wait cycles, the same as an access from idle.
- R7: The first refresh starts REF_INTERVAL + 1 cycles after reset. All four column strobes fall one cycle before all four row strobes fall.
- R8: During a refresh all four row strobes stay low for exactly T_REF_RAS cycles. Afterwards every bank goes through a full precharge.
- R9: A request that arrives while the row strobes of a refresh are low is held with wait high. It sees T_REF_RAS + T_PRE + T_CAS + 1 wait cycles when presented in the first refresh row-strobe cycle.
- R10: A refresh that becomes due during an access starts after that access ends and the banks finish precharging. It takes priority over a request waiting for a different, ready bank, which sees 2*T_PRE + T_REF_RAS + T_CAS + 2 wait cycles.
- R11: An access with page hold set leaves its row strobe low after completion. A following request to the same bank and row skips the row phase and sees T_CAS + 1 wait cycles.
- R12: A request to a different row while a page is open closes the row, waits out precharge, and then runs a full access: T_PRE + T_CAS + 2 wait cycles.
- R13: Address field layout: the top 2 bits of addr_i select the bank (bank b drives ras_n_o[b]), the next AW bits are the row, and the low AW bits are the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until wait_o is seen low |
| wr_i | input | 1 | 1 = write, 0 = read |
| page_i | input | 1 | Keep the row open after this access |
| addr_i | input | 2*AW+2 | Bank, row and column of the access |
| be_i | input | 4 | Byte enables for writes |
| wait_o | output | 1 | Stretch the processor cycle |
| dram_addr_o | output | AW | Multiplexed row/column address |
| ras_n_o | output | 4 | Row strobes, one per bank, active low |
| cas_n_o | output | 4 | Column strobes, one per byte, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
A single read is stepped one clock at a time, so every strobe edge and the switch from row to column address are placed exactly. Back-to-back accesses to the same bank and to another bank are told apart by their wait counts, which shows whether precharge is tracked per bank or globally. Refresh timing is measured from reset. An access presented during the refresh row strobe, and a refresh that falls due in the middle of an access with a second request already queued, separate refresh priority from first-come order. Page-open hits and misses are told apart by their wait counts and by the state of the row strobe after each access.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 2;
    localparam int BYTES     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_OPEN,
        ST_RCAS,
        ST_RRAS
    } ctl_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] count_d, count_q;
    logic          pend_d, pend_q;

    always_comb begin
        count_d = count_q;
        pend_d  = pend_q & ~ack_i;
        if (count_q == '0) begin
            count_d = RELOAD;
            pend_d  = 1'b1;
        end else begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= RELOAD;
            pend_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            pend_q  <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/dram_bank_precharge.sv
module dram_bank_precharge #(
    parameter int NB    = 4,
    parameter int T_PRE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] load_i,
    output logic [NB-1:0] ready_o
);
    localparam int PW = (T_PRE > 1) ? $clog2(T_PRE + 1) : 1;
    localparam logic [PW-1:0] LOAD_VAL = PW'(T_PRE - 1);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [PW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (load_i[b]) begin
                cnt_d = LOAD_VAL;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign ready_o[b] = (cnt_q == '0);
    end
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
    import dram_ctl_pkg::*;
#(
    parameter int AW           = 9,
    parameter int T_CAS        = 2,
    parameter int T_PRE        = 3,
    parameter int T_REF_RAS    = 4,
    parameter int REF_INTERVAL = 300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 wr_i,
    input  logic                 page_i,
    input  logic [2*AW+1:0]      addr_i,
    input  logic [BYTES-1:0]     be_i,
    output logic                 wait_o,
    output logic [AW-1:0]        dram_addr_o,
    output logic [NUM_BANKS-1:0] ras_n_o,
    output logic [BYTES-1:0]     cas_n_o,
    output logic                 we_n_o
);
    localparam int CNT_MAX = (T_CAS > T_REF_RAS) ? T_CAS : T_REF_RAS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CAS_INIT = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] REF_INIT = CNT_W'(T_REF_RAS - 1);

    typedef struct packed {
        ctl_state_e            st;
        logic [CNT_W-1:0]      cnt;
        logic [BANK_W-1:0]     bank;
        logic [AW-1:0]         row;
        logic [AW-1:0]         col;
        logic                  wr;
        logic [BYTES-1:0]      be;
        logic                  page;
        logic [NUM_BANKS-1:0]  ras_n;
        logic [BYTES-1:0]      cas_n;
        logic                  we_n;
        logic [AW-1:0]         addr;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic [BANK_W-1:0]    req_bank;
    logic [AW-1:0]        req_row;
    logic [AW-1:0]        req_col;
    logic                 page_hit;
    logic                 ref_pend;
    logic                 ref_ack;
    logic [NUM_BANKS-1:0] pre_load;
    logic [NUM_BANKS-1:0] pre_ready;

    function automatic logic [NUM_BANKS-1:0] bank_sel(input logic [BANK_W-1:0] b);
        logic [NUM_BANKS-1:0] oh;
        oh    = '0;
        oh[b] = 1'b1;
        return oh;
    endfunction

    assign req_bank = addr_i[2*AW+1 -: BANK_W];
    assign req_row  = addr_i[2*AW-1 -: AW];
    assign req_col  = addr_i[AW-1:0];
    assign page_hit = (req_bank == r_q.bank) && (req_row == r_q.row);

    dram_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ref_ack),
        .pend_o (ref_pend)
    );

    dram_bank_precharge #(
        .NB    (NUM_BANKS),
        .T_PRE (T_PRE)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (pre_load),
        .ready_o (pre_ready)
    );

    always_comb begin
        r_d      = r_q;
        pre_load = '0;
        ref_ack  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    if (&pre_ready) begin
                        ref_ack  = 1'b1;
                        r_d.st   = ST_RCAS;
                        r_d.cas_n = '0;
                    end
                end else if (req_i && pre_ready[req_bank]) begin
                    r_d.st    = ST_ROW;
                    r_d.bank  = req_bank;
                    r_d.row   = req_row;
                    r_d.col   = req_col;
                    r_d.wr    = wr_i;
                    r_d.be    = be_i;
                    r_d.page  = page_i;
                    r_d.ras_n = ~bank_sel(req_bank);
                    r_d.addr  = req_row;
                end
            end
            ST_ROW: begin
                r_d.st   = ST_COL;
                r_d.addr = r_q.col;
                r_d.we_n = ~r_q.wr;
            end
            ST_COL: begin
                r_d.st    = ST_CAS;
                r_d.cas_n = r_q.wr ? ~r_q.be : '0;
                r_d.cnt   = CAS_INIT;
            end
            ST_CAS: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.cas_n = '1;
                    r_d.we_n  = 1'b1;
                    if (r_q.page) begin
                        r_d.st = ST_OPEN;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.ras_n = '1;
                        pre_load  = bank_sel(r_q.bank);
                    end
                end
            end
            ST_OPEN: begin
                if (ref_pend || (req_i && !page_hit)) begin
                    r_d.st    = ST_IDLE;
                    r_d.ras_n = '1;
                    pre_load  = bank_sel(r_q.bank);
                end else if (req_i) begin
                    r_d.st   = ST_COL;
                    r_d.col  = req_col;
                    r_d.wr   = wr_i;
                    r_d.be   = be_i;
                    r_d.page = page_i;
                    r_d.addr = req_col;
                    r_d.we_n = ~wr_i;
                end
            end
            ST_RCAS: begin
                r_d.st    = ST_RRAS;
                r_d.ras_n = '0;
                r_d.cnt   = REF_INIT;
            end
            ST_RRAS: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.ras_n = '1;
                    r_d.cas_n = '1;
                    pre_load  = '1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ras_n <= '1;
            r_q.cas_n <= '1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wait_o      = req_i & ~((r_q.st == ST_CAS) && (r_q.cnt == '0));
    assign dram_addr_o = r_q.addr;
    assign ras_n_o     = r_q.ras_n;
    assign cas_n_o     = r_q.cas_n;
    assign we_n_o      = r_q.we_n;
endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
    parameter int AW    = 9,
    parameter int T_PRE = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          wait_o,
    input logic [AW-1:0] dram_addr_o,
    input logic [3:0]    ras_n_o,
    input logic [3:0]    cas_n_o,
    input logic          we_n_o
);
    p_single_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n_o != 4'h0) |-> ($countones(~ras_n_o) <= 1));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n_o != 4'hF && $past(cas_n_o) != 4'hF) |-> $stable(dram_addr_o));

    p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n_o != 4'hF && $past(cas_n_o) != 4'hF) |-> $stable(we_n_o));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wait_o) |=> (cas_n_o == 4'hF));

    p_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> !wait_o);

    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n_o == 4'h0 && $past(ras_n_o) != 4'h0) |-> ($past(cas_n_o) == 4'h0));

    if (T_PRE > 1) begin : g_pre
        for (genvar b = 0; b < 4; b++) begin : g_bank
            p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ras_n_o[b]) |=> ras_n_o[b]);
        end
    end
endmodule

bind dram_ctl dram_ctl_chk #(
    .AW    (AW),
    .T_PRE (T_PRE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wait_o      (wait_o),
    .dram_addr_o (dram_addr_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o)
);

// File: tb/dram_ctl_tb.sv
`timescale 1ns/1ps
module dram_ctl_tb;
    localparam int AW           = 9;
    localparam int T_CAS        = 2;
    localparam int T_PRE        = 3;
    localparam int T_REF_RAS    = 4;
    localparam int REF_INTERVAL = 300;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic            wr_i = 1'b0;
    logic            page_i = 1'b0;
    logic [2*AW+1:0] addr_i = '0;
    logic [3:0]      be_i = '0;
    logic            wait_o;
    logic [AW-1:0]   dram_addr_o;
    logic [3:0]      ras_n_o;
    logic [3:0]      cas_n_o;
    logic            we_n_o;

    int total = 0;
    int bad   = 0;
    logic [3:0] last_cas;
    logic       last_we;

    always #4 clk = ~clk;

    dram_ctl #(
        .AW (AW), .T_CAS (T_CAS), .T_PRE (T_PRE),
        .T_REF_RAS (T_REF_RAS), .REF_INTERVAL (REF_INTERVAL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_i (req_i), .wr_i (wr_i),
        .page_i (page_i), .addr_i (addr_i), .be_i (be_i), .wait_o (wait_o),
        .dram_addr_o (dram_addr_o), .ras_n_o (ras_n_o), .cas_n_o (cas_n_o),
        .we_n_o (we_n_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        req_i  = 1'b0;
        page_i = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic access(input int bank, input int row, input int col, input bit wr,
                          input logic [3:0] be, input bit pg, output int nw);
        req_i  = 1'b1;
        wr_i   = wr;
        page_i = pg;
        be_i   = be;
        addr_i = {bank[1:0], row[AW-1:0], col[AW-1:0]};
        #1;
        nw = 0;
        while (wait_o && nw < 200) begin
            nw++;
            step();
        end
        last_cas = cas_n_o;
        last_we  = we_n_o;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        chk(ras_n_o == 4'hF, "R1 ras", ras_n_o, 4'hF);
        chk(cas_n_o == 4'hF, "R1 cas", cas_n_o, 4'hF);
        chk(we_n_o == 1'b1, "R1 we", we_n_o, 1);
        chk(dram_addr_o == '0, "R1 addr", dram_addr_o, 0);
        chk(wait_o == 1'b0, "R1 R4 wait idle", wait_o, 0);
    endtask

    task automatic t_sequence();
        do_reset();
        req_i = 1'b1; wr_i = 1'b0; page_i = 1'b0; be_i = 4'h0;
        addr_i = {2'd1, 9'h0A5, 9'h13C};
        #1;
        chk(wait_o == 1'b1, "R4 wait on request", wait_o, 1);
        step();
        chk(ras_n_o == 4'b1101, "R2 R13 bank strobe", ras_n_o, 4'b1101);
        chk(dram_addr_o == 9'h0A5, "R2 R13 row addr", dram_addr_o, 9'h0A5);
        chk(cas_n_o == 4'hF, "R2 cas before col", cas_n_o, 4'hF);
        step();
        chk(dram_addr_o == 9'h13C, "R2 R13 col addr", dram_addr_o, 9'h13C);
        chk(cas_n_o == 4'hF, "R2 cas one clk after col", cas_n_o, 4'hF);
        step();
        chk(cas_n_o == 4'h0, "R2 R3 read cas", cas_n_o, 4'h0);
        chk(we_n_o == 1'b1, "R3 read we", we_n_o, 1);
        for (int i = 1; i < T_CAS; i++) begin
            chk(wait_o == 1'b1, "R4 wait mid cas", wait_o, 1);
            step();
            chk(cas_n_o == 4'h0, "R2 cas width", cas_n_o, 4'h0);
        end
        chk(wait_o == 1'b0, "R4 wait final", wait_o, 0);
        req_i = 1'b0;
        step();
        chk(ras_n_o == 4'hF && cas_n_o == 4'hF, "R2 strobes released",
            {ras_n_o, cas_n_o}, 8'hFF);
    endtask

    task automatic t_write_bytes();
        int nw;
        do_reset();
        access(3, 7, 2, 1'b1, 4'b0101, 1'b0, nw);
        chk(last_cas == 4'b1010, "R3 write byte strobes", last_cas, 4'b1010);
        chk(last_we == 1'b0, "R3 write enable", last_we, 0);
        chk(we_n_o == 1'b1, "R3 we released", we_n_o, 1);
        access(0, 7, 3, 1'b0, 4'b0101, 1'b0, nw);
        chk(last_cas == 4'h0, "R3 read all strobes", last_cas, 4'h0);
        chk(last_we == 1'b1, "R3 read we high", last_we, 1);
        req_i = 1'b0;
    endtask

    task automatic t_banks();
        int nw;
        do_reset();
        access(0, 1, 1, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_CAS + 2, "R4 idle wait count", nw, T_CAS + 2);
        access(0, 2, 2, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_PRE + T_CAS + 1, "R5 same bank waits", nw, T_PRE + T_CAS + 1);
        access(2, 2, 2, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_CAS + 2, "R6 other bank waits", nw, T_CAS + 2);
        req_i = 1'b0;
    endtask

    task automatic t_refresh();
        int n;
        int m;
        do_reset();
        n = 0;
        do begin
            step();
            n++;
        end while (cas_n_o == 4'hF && n < 1000);
        chk(n == REF_INTERVAL + 1, "R7 refresh start", n, REF_INTERVAL + 1);
        chk(cas_n_o == 4'h0 && ras_n_o == 4'hF, "R7 cas before ras",
            {ras_n_o, cas_n_o}, 8'hF0);
        step();
        chk(ras_n_o == 4'h0, "R7 all ras low", ras_n_o, 4'h0);
        m = 0;
        while (ras_n_o == 4'h0 && m < 100) begin
            m++;
            step();
        end
        chk(m == T_REF_RAS, "R8 refresh ras width", m, T_REF_RAS);
        chk(ras_n_o == 4'hF && cas_n_o == 4'hF, "R8 refresh end",
            {ras_n_o, cas_n_o}, 8'hFF);
    endtask

    task automatic t_access_in_refresh();
        int nw;
        do_reset();
        repeat (REF_INTERVAL + 2) step();
        chk(ras_n_o == 4'h0, "R8 refresh ras active", ras_n_o, 4'h0);
        access(1, 4, 4, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_REF_RAS + T_PRE + T_CAS + 1, "R9 held by refresh",
            nw, T_REF_RAS + T_PRE + T_CAS + 1);
        req_i = 1'b0;
    endtask

    task automatic t_refresh_priority();
        int nw;
        do_reset();
        repeat (REF_INTERVAL - 4) step();
        access(0, 9, 9, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_CAS + 2, "R10 access before refresh", nw, T_CAS + 2);
        access(2, 9, 9, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == 2 * T_PRE + T_REF_RAS + T_CAS + 2, "R10 refresh wins",
            nw, 2 * T_PRE + T_REF_RAS + T_CAS + 2);
        req_i = 1'b0;
    endtask

    task automatic t_page();
        int nw;
        do_reset();
        access(1, 5, 3, 1'b0, 4'hF, 1'b1, nw);
        chk(nw == T_CAS + 2, "R11 first page access", nw, T_CAS + 2);
        chk(ras_n_o == 4'b1101, "R11 row held open", ras_n_o, 4'b1101);
        access(1, 5, 7, 1'b0, 4'hF, 1'b1, nw);
        chk(nw == T_CAS + 1, "R11 page hit waits", nw, T_CAS + 1);
        chk(ras_n_o == 4'b1101, "R11 row still open", ras_n_o, 4'b1101);
        access(1, 6, 1, 1'b0, 4'hF, 1'b0, nw);
        chk(nw == T_PRE + T_CAS + 2, "R12 page miss waits", nw, T_PRE + T_CAS + 2);
        chk(ras_n_o == 4'hF, "R12 row closed", ras_n_o, 4'hF);
        req_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_write_bytes();
        t_banks();
        t_refresh();
        t_access_in_refresh();
        t_refresh_priority();
        t_page();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule